// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small 32-bit processor core with hardwired control. Each clock period it fetches one instruction and decodes it with purely combinational logic. It reads two registers, computes in the ALU, optionally reads or writes a word of data memory, and writes one register. At the rising edge that closes the period, the program counter, the register file and the data memory all update together. No other state changes during the period.

The core drives an instruction port and a data port. The instruction port is a combinational read at the program counter. The data port has a combinational read and a write that the memory commits at the rising clock edge when the write strobe is high. The register file and the program counter live inside the block.

Instruction fields use a non-standard placement: the destination register is in the top five bits, followed by the source registers. A per-opcode control table drives explicit selects for:
- the immediate type,
- the second ALU operand,
- the write-back source,
- the write address,
- the next PC.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, `dmem_we` is low. The cycle after a clock edge with `rst` high shows `imem_addr` = 0 and all registers cleared to zero.
- R2: Opcode 0x33 (register-register) uses rd = bits 31:27, rs1 = bits 26:22 and rs2 = bits 21:17. It writes `rd = rs1 op rs2`, where the operation is selected by bits 10:7 as follows: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 signed less-than, 6 unsigned less-than, 7 shift left, 8 logical shift right, 9 arithmetic shift right, any other value add. Shift amounts use the low 5 bits of the second operand.
- R3: Opcode 0x13 (register-immediate) writes `rd = rs1 op sext(bits 21:10)`, where the operation is selected by bits 9:7 as follows: 0 add, 1 shift left, 2 signed less-than, 3 unsigned less-than, 4 xor, 5 logical shift right, 6 or, 7 and.
- R4: Opcode 0x03 (load) reads the word at `rs1 + sext(bits 21:10)` into rd. Opcode 0x23 (store) raises `dmem_we` with address `rs1 + sext({bits 31:27, bits 16:10})` and data rs2. No other opcode raises `dmem_we`.
- R5: Opcode 0x63 (conditional branch) compares rs1 with rs2. The condition is selected by bits 9:7 as follows: 0 equal, 1 not equal, 4 signed less-than, 5 signed greater-or-equal, 6 unsigned less-than, 7 unsigned greater-or-equal. If the condition holds, the next PC is `PC + 2*sext({bits 31:27, bits 16:10})`; otherwise it is PC+4.
- R6: Opcode 0x6F (jump) and opcode 0x6B (jump-and-link) set the next PC to `PC + 2*sext(bits 31:7)`. Jump-and-link also writes PC+4 into register x1.
- R7: Opcode 0x67 (register-indirect jump) sets the next PC to `rs1 + sext(bits 21:10)` and writes PC+4 into rd.
- R8: Register x0 always reads as zero, and writes to x0 are discarded.
- R9: Every ALU, load, store or unrecognised opcode advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed at the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |

## Verification
The bound checker observes the following on every cycle:
- reset behaviour of the PC and the store strobe;
- the PC+4 step after non-control opcodes;
- jump targets;
- the store strobe tracking the store opcode;
- the zero value of x0 seen through store address and store data.

Behaviours that need a chain of instructions can only be shown by the bench's program, with results observed through later stores and the PC trace. These are:
- ALU results;
- taken and untaken branches;
- register-indirect jumps;
- link values;
- load data reaching a register;
- registers cleared by reset.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);

    localparam logic [6:0] OPC_ALU    = 7'h33;
    localparam logic [6:0] OPC_ALUI   = 7'h13;
    localparam logic [6:0] OPC_LOAD   = 7'h03;
    localparam logic [6:0] OPC_STORE  = 7'h23;
    localparam logic [6:0] OPC_BRANCH = 7'h63;
    localparam logic [6:0] OPC_JALR   = 7'h67;
    localparam logic [6:0] OPC_J      = 7'h6F;
    localparam logic [6:0] OPC_JAL    = 7'h6B;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
        ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA
    } alu_op_e;

    typedef enum logic [1:0] {IMM_I, IMM_S, IMM_J} imm_sel_e;
    typedef enum logic       {OP2_REG, OP2_IMM} op2_sel_e;
    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_PC4} wb_sel_e;
    typedef enum logic       {WA_RD, WA_LINK} wa_sel_e;
    typedef enum logic [1:0] {NPC_SEQ, NPC_BR, NPC_RIND, NPC_JREL} npc_sel_e;

    typedef struct packed {
        imm_sel_e imm_sel;
        op2_sel_e op2_sel;
        alu_op_e  alu_op;
        wb_sel_e  wb_sel;
        wa_sel_e  wa_sel;
        npc_sel_e npc_sel;
        logic     reg_we;
        logic     mem_we;
    } ctrl_t;

    function automatic alu_op_e reg_func_op(input logic [3:0] f);
        case (f)
            4'd1:    return ALU_SUB;
            4'd2:    return ALU_AND;
            4'd3:    return ALU_OR;
            4'd4:    return ALU_XOR;
            4'd5:    return ALU_SLT;
            4'd6:    return ALU_SLTU;
            4'd7:    return ALU_SLL;
            4'd8:    return ALU_SRL;
            4'd9:    return ALU_SRA;
            default: return ALU_ADD;
        endcase
    endfunction

    function automatic alu_op_e imm_func_op(input logic [2:0] f);
        case (f)
            3'd1:    return ALU_SLL;
            3'd2:    return ALU_SLT;
            3'd3:    return ALU_SLTU;
            3'd4:    return ALU_XOR;
            3'd5:    return ALU_SRL;
            3'd6:    return ALU_OR;
            3'd7:    return ALU_AND;
            default: return ALU_ADD;
        endcase
    endfunction

    function automatic logic br_cond(input logic [2:0] f,
                                     input logic [XLEN-1:0] a,
                                     input logic [XLEN-1:0] b);
        case (f)
            3'd0:    return a == b;
            3'd1:    return a != b;
            3'd4:    return $signed(a) <  $signed(b);
            3'd5:    return $signed(a) >= $signed(b);
            3'd6:    return a <  b;
            3'd7:    return a >= b;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] func3,
    input  logic [3:0] func4,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{imm_sel: IMM_I, op2_sel: OP2_IMM, alu_op: ALU_ADD,
                 wb_sel: WB_ALU, wa_sel: WA_RD, npc_sel: NPC_SEQ,
                 reg_we: 1'b0, mem_we: 1'b0};
        case (opcode)
            OPC_ALU: begin
                ctrl.op2_sel = OP2_REG;
                ctrl.alu_op  = reg_func_op(func4);
                ctrl.reg_we  = 1'b1;
            end
            OPC_ALUI: begin
                ctrl.alu_op  = imm_func_op(func3);
                ctrl.reg_we  = 1'b1;
            end
            OPC_LOAD: begin
                ctrl.wb_sel  = WB_MEM;
                ctrl.reg_we  = 1'b1;
            end
            OPC_STORE: begin
                ctrl.imm_sel = IMM_S;
                ctrl.mem_we  = 1'b1;
            end
            OPC_BRANCH: begin
                ctrl.imm_sel = IMM_S;
                ctrl.npc_sel = NPC_BR;
            end
            OPC_JALR: begin
                ctrl.wb_sel  = WB_PC4;
                ctrl.npc_sel = NPC_RIND;
                ctrl.reg_we  = 1'b1;
            end
            OPC_J: begin
                ctrl.imm_sel = IMM_J;
                ctrl.npc_sel = NPC_JREL;
            end
            OPC_JAL: begin
                ctrl.imm_sel = IMM_J;
                ctrl.npc_sel = NPC_JREL;
                ctrl.wb_sel  = WB_PC4;
                ctrl.wa_sel  = WA_LINK;
                ctrl.reg_we  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RIDX_W-1:0] ra1,
    input  logic [RIDX_W-1:0] ra2,
    output logic [XLEN-1:0]   rd1,
    output logic [XLEN-1:0]   rd2,
    input  logic              we,
    input  logic [RIDX_W-1:0] wa,
    input  logic [XLEN-1:0]   wd
);
    logic [XLEN-1:0] regs [1:NREG-1];

    generate
        for (genvar i = 1; i < NREG; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs[i] <= '0;
                else if (we && wa == RIDX_W'(i))
                    regs[i] <= wd;
            end
        end
    endgenerate

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    localparam int SH_W = $clog2(XLEN);
    logic [SH_W-1:0] sh;
    assign sh = b[SH_W-1:0];

    always_comb begin
        case (op)
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_SLT:  y = XLEN'($signed(a) < $signed(b));
            ALU_SLTU: y = XLEN'(a < b);
            ALU_SLL:  y = a << sh;
            ALU_SRL:  y = a >> sh;
            ALU_SRA:  y = XLEN'($signed(a) >>> sh);
            default:  y = a + b;
        endcase
    end
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);
    logic [XLEN-1:0]   pc_q, pc_next, pc_plus4;
    logic [XLEN-1:0]   inst, imm, op2, alu_y, rs1_v, rs2_v, wb_v;
    logic [RIDX_W-1:0] wa;
    ctrl_t             ctrl;

    assign inst      = imem_rdata;
    assign imem_addr = pc_q;
    assign pc_plus4  = pc_q + XLEN'(4);

    sc_decode u_dec (
        .opcode (inst[6:0]),
        .func3  (inst[9:7]),
        .func4  (inst[10:7]),
        .ctrl   (ctrl)
    );

    always_comb begin
        case (ctrl.imm_sel)
            IMM_S:   imm = {{(XLEN-12){inst[31]}}, inst[31:27], inst[16:10]};
            IMM_J:   imm = {{(XLEN-25){inst[31]}}, inst[31:7]};
            default: imm = {{(XLEN-12){inst[21]}}, inst[21:10]};
        endcase
    end

    assign wa = (ctrl.wa_sel == WA_LINK) ? RIDX_W'(1) : inst[31:27];

    sc_regfile u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (inst[26:22]),
        .ra2 (inst[21:17]),
        .rd1 (rs1_v),
        .rd2 (rs2_v),
        .we  (ctrl.reg_we & ~rst),
        .wa  (wa),
        .wd  (wb_v)
    );

    assign op2 = (ctrl.op2_sel == OP2_IMM) ? imm : rs2_v;

    sc_alu u_alu (
        .op (ctrl.alu_op),
        .a  (rs1_v),
        .b  (op2),
        .y  (alu_y)
    );

    assign dmem_addr  = alu_y;
    assign dmem_wdata = rs2_v;
    assign dmem_we    = ctrl.mem_we & ~rst;

    always_comb begin
        case (ctrl.wb_sel)
            WB_MEM:  wb_v = dmem_rdata;
            WB_PC4:  wb_v = pc_plus4;
            default: wb_v = alu_y;
        endcase
    end

    always_comb begin
        case (ctrl.npc_sel)
            NPC_BR:   pc_next = br_cond(inst[9:7], rs1_v, rs2_v)
                                ? pc_q + (imm << 1) : pc_plus4;
            NPC_RIND: pc_next = alu_y;
            NPC_JREL: pc_next = pc_q + (imm << 1);
            default:  pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= pc_next;
    end
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_rdata,
    input logic [31:0] dmem_addr,
    input logic [31:0] dmem_wdata,
    input logic        dmem_we
);
    logic [6:0]  opc;
    logic [31:0] s_imm, j_off;
    logic        seq_op;

    assign opc    = imem_rdata[6:0];
    assign s_imm  = {{20{imem_rdata[31]}}, imem_rdata[31:27], imem_rdata[16:10]};
    assign j_off  = {{6{imem_rdata[31]}}, imem_rdata[31:7], 1'b0};
    assign seq_op = (opc != OPC_BRANCH) && (opc != OPC_JALR)
                 && (opc != OPC_J) && (opc != OPC_JAL);

    p_reset_pc_r1: assert property (@(posedge clk)
        rst |=> imem_addr == 32'h0);

    p_reset_no_store_r1: assert property (@(posedge clk)
        rst |-> !dmem_we);

    p_store_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        dmem_we == (opc == OPC_STORE));

    p_seq_pc_r9: assert property (@(posedge clk) disable iff (rst)
        seq_op |=> imem_addr == $past(imem_addr) + 32'd4);

    p_jump_target_r6: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_J || opc == OPC_JAL) |=> imem_addr == $past(imem_addr + j_off));

    p_zero_base_r8: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_STORE && imem_rdata[26:22] == 5'd0) |-> dmem_addr == s_imm);

    p_zero_data_r8: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_STORE && imem_rdata[21:17] == 5'd0) |-> dmem_wdata == 32'h0);
endmodule

bind sc_core sc_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we)
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    int          n_run  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #2.5 clk = ~clk;

    sc_core dut_i (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    typedef struct packed {
        logic [23:0] tag;
        logic [31:0] pc;
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
    } step_t;

    localparam int NSTEP = 24;
    localparam step_t TRACE [NSTEP] = '{
        '{"R9 ", 32'h00, 1'b0, 32'h0, 32'h0},
        '{"R9 ", 32'h04, 1'b0, 32'h0, 32'h0},
        '{"R9 ", 32'h08, 1'b0, 32'h0, 32'h0},
        '{"R9 ", 32'h0C, 1'b0, 32'h0, 32'h0},
        '{"R9 ", 32'h10, 1'b0, 32'h0, 32'h0},
        '{"R9 ", 32'h14, 1'b0, 32'h0, 32'h0},
        '{"R9 ", 32'h18, 1'b0, 32'h0, 32'h0},
        '{"R2 ", 32'h1C, 1'b1, 32'h40, 32'h8},
        '{"R3 ", 32'h20, 1'b1, 32'h44, 32'hFFFF_FFFF},
        '{"R9 ", 32'h24, 1'b0, 32'h0, 32'h0},
        '{"R9 ", 32'h28, 1'b0, 32'h0, 32'h0},
        '{"R8 ", 32'h2C, 1'b1, 32'h48, 32'h0},
        '{"R5 ", 32'h30, 1'b0, 32'h0, 32'h0},
        '{"R5 ", 32'h38, 1'b0, 32'h0, 32'h0},
        '{"R5 ", 32'h3C, 1'b0, 32'h0, 32'h0},
        '{"R5 ", 32'h44, 1'b0, 32'h0, 32'h0},
        '{"R5 ", 32'h48, 1'b0, 32'h0, 32'h0},
        '{"R6 ", 32'h50, 1'b1, 32'h4C, 32'h4C},
        '{"R9 ", 32'h54, 1'b0, 32'h0, 32'h0},
        '{"R3 ", 32'h58, 1'b0, 32'h0, 32'h0},
        '{"R7 ", 32'h68, 1'b1, 32'h50, 32'h5C},
        '{"R4 ", 32'h6C, 1'b1, 32'h54, 32'h8},
        '{"R6 ", 32'h70, 1'b0, 32'h0, 32'h0},
        '{"R6 ", 32'h70, 1'b0, 32'h0, 32'h0}
    };

    function automatic logic [31:0] e_r(int rd, int rs1, int rs2, int f);
        return {5'(rd), 5'(rs1), 5'(rs2), 10'(f), 7'h33};
    endfunction
    function automatic logic [31:0] e_i(logic [6:0] op, int rd, int rs1, int imm, int f);
        return {5'(rd), 5'(rs1), 12'(imm), 3'(f), op};
    endfunction
    function automatic logic [31:0] e_s(logic [6:0] op, int rs1, int rs2, int imm, int f);
        logic [11:0] v;
        v = 12'(imm);
        return {v[11:7], 5'(rs1), 5'(rs2), v[6:0], 3'(f), op};
    endfunction
    function automatic logic [31:0] e_j(logic [6:0] op, int off);
        return {25'(off), op};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
        imem[0]  = e_i(7'h13, 1, 0, 5, 0);         // addi x1 = 5
        imem[1]  = e_i(7'h13, 2, 0, -3, 0);        // addi x2 = -3
        imem[2]  = e_r(3, 1, 2, 0);                // add  x3 = 2
        imem[3]  = e_r(4, 1, 2, 1);                // sub  x4 = 8
        imem[4]  = e_r(5, 2, 1, 5);                // slt  x5 = 1
        imem[5]  = e_r(6, 2, 1, 6);                // sltu x6 = 0
        imem[6]  = e_r(7, 2, 3, 9);                // sra  x7 = -1
        imem[7]  = e_s(7'h23, 0, 4, 'h40, 2);      // sw x4
        imem[8]  = e_s(7'h23, 0, 7, 'h44, 2);      // sw x7
        imem[9]  = e_i(7'h03, 8, 0, 'h40, 2);      // lw x8
        imem[10] = e_i(7'h13, 0, 0, 7, 0);         // addi x0 (discarded)
        imem[11] = e_s(7'h23, 0, 0, 'h48, 2);      // sw x0
        imem[12] = e_s(7'h63, 1, 1, 4, 0);         // beq taken
        imem[13] = e_i(7'h13, 9, 0, 1, 0);
        imem[14] = e_s(7'h63, 1, 1, 4, 1);         // bne not taken
        imem[15] = e_s(7'h63, 2, 1, 4, 4);         // blt taken
        imem[16] = e_i(7'h13, 9, 0, 1, 0);
        imem[17] = e_s(7'h63, 2, 1, 4, 6);         // bltu not taken
        imem[18] = e_j(7'h6B, 4);                  // jal +8
        imem[19] = e_i(7'h13, 9, 0, 1, 0);
        imem[20] = e_s(7'h23, 0, 1, 'h4C, 2);      // sw x1 (link)
        imem[21] = e_i(7'h13, 10, 0, 'h64, 0);     // addi x10 = 100
        imem[22] = e_i(7'h67, 11, 10, 4, 0);       // jalr x11, 4(x10)
        imem[26] = e_s(7'h23, 0, 11, 'h50, 2);     // sw x11
        imem[27] = e_s(7'h23, 0, 8, 'h54, 2);      // sw x8 (loaded)
        imem[28] = e_j(7'h6F, 0);                  // jump to self

        repeat (3) @(negedge clk);
        chk(imem_addr == 32'h0, "R1 reset pc", imem_addr, 32'h0);
        chk(dmem_we == 1'b0, "R1 reset we", 32'(dmem_we), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NSTEP; i++) begin
            #0.5;
            chk(imem_addr == TRACE[i].pc, string'(TRACE[i].tag), imem_addr, TRACE[i].pc);
            chk(dmem_we == TRACE[i].we, string'(TRACE[i].tag), 32'(dmem_we), 32'(TRACE[i].we));
            if (TRACE[i].we) begin
                chk(dmem_addr == TRACE[i].addr, string'(TRACE[i].tag), dmem_addr, TRACE[i].addr);
                chk(dmem_wdata == TRACE[i].wdata, string'(TRACE[i].tag), dmem_wdata, TRACE[i].wdata);
            end
            @(negedge clk);
        end

        // R4: committed stores landed in memory
        chk(dmem[16] == 32'h8,         "R4 mem 0x40", dmem[16], 32'h8);
        chk(dmem[17] == 32'hFFFF_FFFF, "R2 mem 0x44", dmem[17], 32'hFFFF_FFFF);
        chk(dmem[19] == 32'h4C,        "R6 mem 0x4C", dmem[19], 32'h4C);
        chk(dmem[21] == 32'h8,         "R4 mem 0x54", dmem[21], 32'h8);

        // R1: store held off in reset, registers cleared afterwards
        rst = 1'b1;
        imem[0] = e_s(7'h23, 0, 5, 'h58, 2);       // sw x5 (x5 was 1)
        @(negedge clk);
        chk(imem_addr == 32'h0, "R1 pc after reset", imem_addr, 32'h0);
        chk(dmem_we == 1'b0, "R1 we held in reset", 32'(dmem_we), 32'h0);
        rst = 1'b0;
        #0.5;
        chk(dmem_we == 1'b1, "R1 store after reset", 32'(dmem_we), 32'h1);
        chk(dmem_wdata == 32'h0, "R1 register cleared", dmem_wdata, 32'h0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule